// File: doc/BRIEF.md
# Multi-Drop Receiver Wakeup Controller

On a serial line shared by several receivers, every receiver hears every character, but most messages are meant for only one of them. This block sits beside one receiver's frame decoder and decides whether the decoder's status events reach the flags that software watches. When software sees that a message is addressed elsewhere, it puts the receiver to sleep. From then on, completed characters and idle-line events stop raising flags. The hardware wakes the receiver again at the right moment.

Two wake methods are available, picked by a select input. In idle-line mode the receiver wakes when the line goes quiet after the unwanted message, so that the first character of the next message is delivered. In address-mark mode the top bit of each character tells address characters (1) from data characters (0). An address character wakes every sleeping receiver, and that character is itself delivered so that software can compare the address.

Top module: `rx_wake_ctrl`

## Requirements
- R1: After reset, `sleep` is 0 and neither `data_full_set` nor `idle_flag_set` is asserted.
- R2: A `sleep_req` pulse while `rx_enable` is 1 makes `sleep` 1 from the next cycle. While `rx_enable` is 0 the pulse is ignored.
- R3: While awake and enabled, `char_done` asserts `data_full_set` in the same cycle and `idle_pulse` asserts `idle_flag_set` in the same cycle.
- R4: While asleep, a character whose top bit (`char_data[CHAR_W-1]`) is 0 does not assert `data_full_set` in either mode, and `idle_pulse` never asserts `idle_flag_set`.
- R5: In idle-line mode (`wake_mode` = 0), an `idle_pulse` while asleep clears `sleep` from the next cycle, provided at least one character has completed since sleep was requested. That pulse does not assert `idle_flag_set`.
- R6: In idle-line mode, an `idle_pulse` while asleep with no character completed since the sleep request leaves `sleep` at 1.
- R7: In address-mark mode (`wake_mode` = 1), a character with top bit 1 while asleep asserts `data_full_set` in the same cycle and clears `sleep` from the next cycle.
- R8: Each mode ignores the other mode's wake event. In address-mark mode an `idle_pulse` leaves `sleep` at 1. In idle-line mode a character with top bit 1 leaves `sleep` at 1 and is not delivered.
- R9: While `rx_enable` is 0, both flag outputs are 0, and `sleep` is 0 from the next cycle.
- R10: A `sleep_req` in the same cycle as a wake event wins, and `sleep` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; 0 clears sleep and blocks flags |
| wake_mode | input | 1 | 0 = idle-line wake, 1 = address-mark wake |
| sleep_req | input | 1 | Software write pulse setting the sleep bit |
| char_done | input | 1 | One-cycle pulse: a character has been received |
| char_data | input | CHAR_W | Received character; top bit is the address mark |
| idle_pulse | input | 1 | One-cycle pulse: idle line detected |
| sleep | output | 1 | Current sleep bit |
| data_full_set | output | 1 | Permit to set the receive-data-full flag this cycle |
| idle_flag_set | output | 1 | Permit to set the idle flag this cycle |

## Verification
The bench builds the block with CHAR_W = 4, so that all sixteen character values can be driven against each mode. It also covers all 64 combinations of the six control inputs, starting from each reachable internal condition: awake, asleep with no character seen, and asleep after a character. Every same-cycle collision of a sleep request with a wake or disable event is therefore reached. Directed sequences cover the idle-while-idle case and the address character being delivered.

// File: rtl/rx_wake_pkg.sv
// Shared types for the receiver wakeup controller.
package rx_wake_pkg;
    typedef enum logic {
        WAKE_IDLE_LINE = 1'b0,
        WAKE_ADDR_MARK = 1'b1
    } wake_mode_e;
endpackage

// File: rtl/rx_wake_sleep.sv
// Sleep state holder.
// Holds the software-set sleep bit, and a "re-armed" bit that records whether
// line activity (a completed character) has been seen since sleep was set.
// Assumes char_done and idle_pulse are single-cycle pulses from the decoder.
module rx_wake_sleep
    import rx_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_enable,
    input  wake_mode_e mode,
    input  logic       sleep_req,
    input  logic       char_done,
    input  logic       char_msb,
    input  logic       idle_pulse,
    output logic       sleep_o
);
    logic sleep_q;
    logic armed_q;
    logic wake_idle;
    logic wake_addr;

    // Wake conditions for each method.
    always_comb begin
        wake_idle = sleep_q && (mode == WAKE_IDLE_LINE) && idle_pulse && armed_q;
        wake_addr = sleep_q && (mode == WAKE_ADDR_MARK) && char_done && char_msb;
    end

    // Sleep bit: disable clears, software sets (wins), selected wake event clears.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_enable) begin
            sleep_q <= 1'b0;
        end else if (sleep_req) begin
            sleep_q <= 1'b1;
        end else if (wake_idle || wake_addr) begin
            sleep_q <= 1'b0;
        end
    end

    // Re-arm tracker: set by a character completing during sleep.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_enable || sleep_req || !sleep_q) begin
            armed_q <= 1'b0;
        end else if (char_done) begin
            armed_q <= 1'b1;
        end
    end

    assign sleep_o = sleep_q;

    assert_sleep_from_sw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_q) |-> $past(sleep_req));

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !sleep_q);

    assert_unarmed_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_q && !armed_q && rx_enable && !char_done) |=> sleep_q);

    assert_wake_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_q) |-> ($past(!rx_enable) || $past(idle_pulse) || $past(char_done && char_msb)));
endmodule

// File: rtl/rx_wake_gate.sv
// Flag gate.
// Decides in the current cycle whether a decoder event may reach its status flag.
// An address character in address-mark mode passes even while asleep.
// Assumes sleep reflects the registered state before this cycle's edge.
module rx_wake_gate
    import rx_wake_pkg::*;
(
    input  logic       rx_enable,
    input  wake_mode_e mode,
    input  logic       sleep,
    input  logic       char_done,
    input  logic       char_msb,
    input  logic       idle_pulse,
    output logic       data_full_set,
    output logic       idle_flag_set
);
    logic addr_pass;

    // Combine enable, sleep state and wake exception into the two permits.
    always_comb begin
        addr_pass     = (mode == WAKE_ADDR_MARK) && char_msb;
        data_full_set = rx_enable && char_done && (!sleep || addr_pass);
        idle_flag_set = rx_enable && idle_pulse && !sleep;
    end
endmodule

// File: rtl/rx_wake_ctrl.sv
// Receiver wakeup controller (top).
// Gates receive status updates with a software-set sleep bit that hardware
// clears on the wake event of the selected method.
// Assumes the character's top bit is the address mark.
module rx_wake_ctrl
    import rx_wake_pkg::*;
#(
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              wake_mode,
    input  logic              sleep_req,
    input  logic              char_done,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              idle_pulse,
    output logic              sleep,
    output logic              data_full_set,
    output logic              idle_flag_set
);
    localparam int MarkBit = CHAR_W - 1;

    wake_mode_e mode;
    logic       char_msb;

    // Decode the method select and pick out the address mark.
    always_comb begin
        mode     = wake_mode_e'(wake_mode);
        char_msb = char_data[MarkBit];
    end

    rx_wake_sleep u_sleep (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_enable  (rx_enable),
        .mode       (mode),
        .sleep_req  (sleep_req),
        .char_done  (char_done),
        .char_msb   (char_msb),
        .idle_pulse (idle_pulse),
        .sleep_o    (sleep)
    );

    rx_wake_gate u_gate (
        .rx_enable     (rx_enable),
        .mode          (mode),
        .sleep         (sleep),
        .char_done     (char_done),
        .char_msb      (char_msb),
        .idle_pulse    (idle_pulse),
        .data_full_set (data_full_set),
        .idle_flag_set (idle_flag_set)
    );

    assert_addr_wakes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_full_set && sleep && !sleep_req && rx_enable) |=> !sleep);

    assert_asleep_no_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && idle_pulse) |-> !idle_flag_set);

    assert_req_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && rx_enable) |=> sleep);
endmodule

// File: tb/rx_wake_ctrl_bench.sv
`timescale 1ns/100ps
module rx_wake_ctrl_bench;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, md = 1'b0, sreq = 1'b0, cd = 1'b0, idl = 1'b0;
    logic [CW-1:0] dat = '0;
    logic slp, dfs, ifs;

    int checks = 0;
    int errors = 0;
    bit m_sleep = 1'b0;
    bit m_armed = 1'b0;

    always #2 clk = ~clk;

    rx_wake_ctrl #(.CHAR_W(CW)) u_rx_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_enable(en), .wake_mode(md),
        .sleep_req(sreq), .char_done(cd), .char_data(dat), .idle_pulse(idl),
        .sleep(slp), .data_full_set(dfs), .idle_flag_set(ifs));

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, check same-cycle permits, clock, check sleep.
    task automatic cyc(input string tag, input bit e, input bit m, input bit s,
                       input bit c, input logic [CW-1:0] d, input bit i);
        bit msb, xd, xi, ns, na;
        en = e; md = m; sreq = s; cd = c; dat = d; idl = i;
        msb = d[CW-1];
        xd = e && c && (!m_sleep || (m && msb));
        xi = e && i && !m_sleep;
        if (!e) begin ns = 0; na = 0; end
        else if (s) begin ns = 1; na = 0; end
        else begin
            ns = m_sleep;
            if (m_sleep && !m && i && m_armed) ns = 0;
            if (m_sleep && m && c && msb) ns = 0;
            na = m_sleep ? (m_armed || c) : 1'b0;
        end
        #1;
        chk(tag, "data_full_set", dfs, xd);
        chk(tag, "idle_flag_set", ifs, xi);
        @(posedge clk);
        m_sleep = ns; m_armed = na;
        #1;
        chk(tag, "sleep", slp, ns);
    endtask

    task automatic quiet(input string tag, input bit m);
        cyc(tag, 1, m, 0, 0, '0, 0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "sleep", slp, 1'b0);
        chk("R1", "data_full_set", dfs, 1'b0);
        chk("R1", "idle_flag_set", ifs, 1'b0);
        rst_n = 1'b1;

        // R2: ignored while disabled, honoured while enabled
        cyc("R2", 0, 0, 1, 0, '0, 0);
        cyc("R2", 1, 0, 1, 0, '0, 0);
        cyc("R9", 0, 0, 0, 1, 4'hF, 1);
        // R3: awake delivery for every character in both modes
        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 16; d++) cyc("R3", 1, m[0], 0, 1, d[CW-1:0], d[0]);
        // R4/R7/R8: asleep, every character in both modes
        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 16; d++) begin
                cyc("R4", 0, m[0], 0, 0, '0, 0);
                cyc("R2", 1, m[0], 1, 0, '0, 0);
                cyc(d[CW-1] ? (m ? "R7" : "R8") : "R4", 1, m[0], 0, 1, d[CW-1:0], 0);
                quiet("R4", m[0]);
            end
        // R6 then R5: idle while already idle, then activity and new idle
        cyc("R9", 0, 0, 0, 0, '0, 0);
        cyc("R2", 1, 0, 1, 0, '0, 0);
        cyc("R6", 1, 0, 0, 0, '0, 1);
        chk("R6", "still asleep", slp, 1'b1);
        cyc("R4", 1, 0, 0, 1, 4'h3, 0);
        cyc("R5", 1, 0, 0, 0, '0, 1);
        chk("R5", "woken", slp, 1'b0);
        // R8: address mode ignores idle even after activity
        cyc("R2", 1, 1, 1, 0, '0, 0);
        cyc("R4", 1, 1, 0, 1, 4'h1, 0);
        cyc("R8", 1, 1, 0, 0, '0, 1);
        chk("R8", "still asleep", slp, 1'b1);
        // R10: request collides with address wake
        cyc("R10", 1, 1, 1, 1, 4'h8, 0);
        chk("R10", "asleep", slp, 1'b1);

        // Sweep: 64 input combinations from each internal condition
        for (int st = 0; st < 3; st++)
            for (int m = 0; m < 2; m++)
                for (int k = 0; k < 64; k++) begin
                    cyc("SWEEP", 0, m[0], 0, 0, '0, 0);
                    if (st >= 1) cyc("SWEEP", 1, m[0], 1, 0, '0, 0);
                    if (st == 2) cyc("SWEEP", 1, m[0], 0, 1, 4'h2, 0);
                    cyc("SWEEP", k[0], k[1] ^ m[0], k[2], k[3], {k[4], k[5], 2'b01}, k[5]);
                    quiet("SWEEP", m[0]);
                end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule